// File: doc/BRIEF.md
# Bit-Serial Addressed I/O Port

This block moves a field of 1 to 16 bits between a 16-bit parallel word on the CPU side and a single-bit I/O bus. The I/O space is 4096 bits. Each bit has its own address, and this I/O path is separate from the parallel memory bus. The CPU side supplies the following and then raises `start_i` for one cycle:
- a 12-bit starting bit address,
- a length code,
- a direction,
- a data word.

The block then steps through consecutive bit addresses, one per cycle. For an output transfer it writes one data bit with each strobe. For an input transfer it samples one bit per address and builds the result word.

A field may start at any bit address and may run past the top of the space, because addresses wrap modulo 4096. Word bits are numbered here the conventional way, with bit 0 as the least significant. In a most-significant-first numbering that same first-sent bit is bit 15. Field bit k corresponds to word bit k and to bus address base+k. Input results are right-justified, and the unused upper positions read as zero. `done_o` pulses for one cycle when the transfer completes.

Top module: `sbio_port`

## Requirements
- R1: While idle, a cycle with `start_i` high is accepted. In the next cycle `busy_o` is 1 and `io_addr_o` equals `base_addr_i`.
- R2: The length code `len_i` selects n = `len_i` bits for codes 1..15 and n = 16 bits for code 0. An output transfer issues exactly n strobes, and an input transfer issues none.
- R3: In the k-th bit cycle after acceptance (k = 0..n-1), `io_addr_o` equals (base + k) mod 4096.
- R4: When `dir_wr_i` = 1 (output), each bit cycle raises `io_wr_o` for one cycle with `io_dout_o` equal to word bit k, where bit 0 is the LSB. That bit is numbered 15 in a most-significant-first numbering. No address outside the field is written, and word bits at or above n are not sent.
- R5: When `dir_wr_i` = 0 (input), `io_din_i` is sampled one cycle after its address is presented on `io_addr_o`. Bit k of `rdata_o` takes the sample from address base+k. Bits n..15 of `rdata_o` are 0.
- R6: `done_o` is high for exactly one cycle. For an output transfer it is high in cycle n+1 after acceptance, and for an input transfer in cycle n+2. `rdata_o` is complete in the `done_o` cycle.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running transfer keeps its own address, length, direction and data.
- R8: During reset, `busy_o`, `done_o` and `io_wr_o` are 0 and `rdata_o` is 0.
- R9: `busy_o` is 0 in the `done_o` cycle, and a `start_i` in that same cycle is accepted without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| dir_wr_i | input | 1 | 1 = output transfer, 0 = input transfer |
| base_addr_i | input | 12 | First bit address of the field |
| len_i | input | 4 | Field length code, 0 means 16 |
| wdata_i | input | 16 | Word to send, LSB first |
| rdata_o | output | 16 | Assembled input word, right-justified |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |
| io_addr_o | output | 12 | Bit address on the I/O bus |
| io_dout_o | output | 1 | Output data bit |
| io_wr_o | output | 1 | One-cycle write strobe |
| io_din_i | input | 1 | Input data bit, valid one cycle after its address |

## Verification
All timing is counted from the edge that accepts `start_i`.
- **Address and strobe:** these are due in cycles 1 through n. The bench compares them once per cycle at the falling edge, against base+cycle-1.
- **Output completion:** `done_o` is expected in cycle n+1. The write results are then checked against a bench-side bit-array device that stores each strobed bit on the following rising edge.
- **Input completion:** `done_o` is expected in cycle n+2, because the device model registers its read data by one cycle. `rdata_o` is compared only in that `done_o` cycle.
- **Ignored and back-to-back starts:** the bench checks that a `start_i` injected mid-transfer leaves all of these timings unchanged. It also checks that the next transfer starts in the `done_o` cycle itself.

// File: rtl/sbio_pkg.sv
package sbio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } sbio_state_e;
endpackage

// File: rtl/sbio_seq.sv
module sbio_seq
  import sbio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_wr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  output logic              accept_o,
  output logic              strobe_o,
  output logic              samp_o,
  output logic [IDX_W-1:0]  samp_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o
);
  sbio_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q, last_q, samp_idx_q;
  logic              dir_q, done_q, samp_q;
  logic              last_bit;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_bit = (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= base_i;
          idx_q   <= '0;
          last_q  <= len_i - 1'b1;  // code 0 wraps to full width
          dir_q   <= dir_wr_i;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          addr_q <= addr_q + 1'b1;
          idx_q  <= idx_q + 1'b1;
          if (last_bit) begin
            if (dir_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_DRAIN;  // wait for final input sample
            end
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // input data returns one cycle after its address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q     <= 1'b0;
      samp_idx_q <= '0;
    end else begin
      samp_q     <= (state_q == ST_XFER) && !dir_q;
      samp_idx_q <= idx_q;
    end
  end

  assign strobe_o   = (state_q == ST_XFER) && dir_q;
  assign samp_o     = samp_q;
  assign samp_idx_o = samp_idx_q;
  assign addr_o     = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && !last_bit) |=> (addr_q == $past(addr_q) + 1'b1));

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> ($stable(last_q) && $stable(dir_q)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/sbio_shift.sv
module sbio_shift #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dir_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              samp_i,
  input  logic [IDX_W-1:0]  samp_idx_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i && dir_wr_i) begin
      tx_q <= wdata_i;
    end else if (shift_i) begin
      tx_q <= tx_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (load_i && !dir_wr_i) begin
      rx_q <= '0;  // unused upper bits stay zero
    end else if (samp_i) begin
      rx_q[samp_idx_i] <= din_i;
    end
  end

  assign dout_o  = tx_q[0];
  assign rdata_o = rx_q;

  p_rx_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !dir_wr_i) |=> (rx_q == '0));
endmodule

// File: rtl/sbio_port.sv
module sbio_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_wr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              io_dout_o,
  output logic              io_wr_o,
  input  logic              io_din_i
);
  logic             accept, strobe, samp;
  logic [IDX_W-1:0] samp_idx;

  sbio_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dir_wr_i   (dir_wr_i),
    .base_i     (base_addr_i),
    .len_i      (len_i),
    .accept_o   (accept),
    .strobe_o   (strobe),
    .samp_o     (samp),
    .samp_idx_o (samp_idx),
    .addr_o     (io_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  sbio_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .dir_wr_i   (dir_wr_i),
    .wdata_i    (wdata_i),
    .shift_i    (strobe),
    .samp_i     (samp),
    .samp_idx_i (samp_idx),
    .din_i      (io_din_i),
    .dout_o     (io_dout_o),
    .rdata_o    (rdata_o)
  );

  assign io_wr_o = strobe;

  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  p_idle_no_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !io_wr_o);
endmodule

// File: tb/tb_sbio_port.sv
`timescale 1ns/1ps
module tb_sbio_port;
  localparam int NV = 10;
  // entry: {wr, len[3:0], base[11:0], data[15:0]}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 4'd1,  12'h000, 16'h0001},
    {1'b0, 4'd1,  12'h000, 16'h0000},
    {1'b1, 4'd0,  12'h123, 16'hA5C3},
    {1'b0, 4'd0,  12'h123, 16'h0000},
    {1'b1, 4'd5,  12'hFFE, 16'h0015},
    {1'b0, 4'd5,  12'hFFE, 16'h0000},
    {1'b0, 4'd7,  12'h120, 16'hFFFF},
    {1'b1, 4'd3,  12'h7FF, 16'hFFF8},
    {1'b0, 4'd9,  12'h7FD, 16'h0000},
    {1'b0, 4'd0,  12'hFF8, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir_wr = 1'b0, din_q;
  logic [11:0] base = '0, io_addr;
  logic [3:0]  len = '0;
  logic [15:0] wdata = '0, rdata;
  logic done, busy, io_dout, io_wr;
  logic [4095:0] io_mem, exp_mem;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sbio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_wr_i(dir_wr),
    .base_addr_i(base), .len_i(len), .wdata_i(wdata), .rdata_o(rdata),
    .done_o(done), .busy_o(busy), .io_addr_o(io_addr), .io_dout_o(io_dout),
    .io_wr_o(io_wr), .io_din_i(din_q)
  );

  function automatic logic [4095:0] pattern();
    logic [4095:0] p;
    for (int i = 0; i < 4096; i++) p[i] = (((i * 37) >> 2) ^ (i >> 5)) & 1;
    return p;
  endfunction

  // bit-array device: writes on strobe, read data registered one cycle
  always @(posedge clk) begin
    if (!rst_n) io_mem <= pattern();
    else if (io_wr) io_mem[io_addr] <= io_dout;
    din_q <= io_mem[io_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // called at a falling edge; drives start right away (back-to-back capable)
  task automatic run_xfer(input logic wr, input logic [3:0] l, input logic [11:0] b,
                          input logic [15:0] d, input bit inject);
    int n, cyc, addr_err, dout_err, strobes, expc;
    logic [15:0] expw;
    logic [11:0] ea;
    n = (l == 0) ? 16 : int'(l);
    start = 1'b1; dir_wr = wr; len = l; base = b; wdata = d;
    @(negedge clk);
    start = 1'b0; dir_wr = ~wr; len = 4'd2; base = 12'h555; wdata = 16'h5A5A;
    chk(busy === 1'b1, "R1 busy after accept", 32'(busy), 1);
    chk(io_addr === b, "R1 first address", 32'(io_addr), 32'(b));
    chk(done === 1'b0, "R6 done width", 32'(done), 0);
    cyc = 1; addr_err = 0; dout_err = 0; strobes = 0;
    while (!done && cyc < 40) begin
      ea = b + 12'(cyc - 1);
      if (cyc <= n && io_addr !== ea) addr_err++;
      if (io_wr) begin
        strobes++;
        if (io_dout !== d[cyc-1]) dout_err++;
      end
      if (inject && cyc == 2) begin
        start = 1'b1; dir_wr = ~wr; len = 4'd1; base = 12'h3C3; wdata = ~d;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    expc = wr ? n + 1 : n + 2;
    chk(cyc == expc, inject ? "R7 timing with ignored start" : "R6 done cycle", 32'(cyc), 32'(expc));
    chk(addr_err == 0, "R3 address sequence", 32'(addr_err), 0);
    chk(busy === 1'b0, "R9 idle in done cycle", 32'(busy), 0);
    if (wr) begin
      for (int k = 0; k < n; k++) exp_mem[12'(int'(b) + k)] = d[k];
      chk(strobes == n, "R2 strobe count", 32'(strobes), 32'(n));
      chk(dout_err == 0, "R4 output bit values", 32'(dout_err), 0);
    end else begin
      expw = '0;
      for (int k = 0; k < n; k++) expw[k] = exp_mem[12'(int'(b) + k)];
      chk(strobes == 0, "R2 no strobe on input", 32'(strobes), 0);
      chk(rdata === expw, inject ? "R7 read data kept" : "R5 read data", 32'(rdata), 32'(expw));
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    exp_mem = pattern();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R8 reset busy", 32'(busy), 0);
    chk(done === 1'b0, "R8 reset done", 32'(done), 0);
    chk(io_wr === 1'b0, "R8 reset strobe", 32'(io_wr), 0);
    chk(rdata === 16'h0, "R8 reset rdata", 32'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i][32], VEC[i][31:28], VEC[i][27:16], VEC[i][15:0], 1'b0);
      chk(io_mem === exp_mem, "R4 device contents", 32'(i), 32'(i));
    end
    // directed: ignored start during output and input transfers
    run_xfer(1'b1, 4'd6, 12'h400, 16'h002D, 1'b1);
    chk(io_mem === exp_mem, "R7 device contents after ignored start", 0, 0);
    run_xfer(1'b0, 4'd6, 12'h400, 16'h0000, 1'b1);
    // directed: full 16-bit write wrapping the top of the space, read back
    run_xfer(1'b1, 4'd0, 12'hFF4, 16'h8E71, 1'b0);
    chk(io_mem === exp_mem, "R3 wrapped write contents", 0, 0);
    run_xfer(1'b0, 4'd0, 12'hFF4, 16'h0000, 1'b0);
    // directed: single-bit input, upper 15 bits must read zero
    run_xfer(1'b0, 4'd1, 12'h001, 16'h0000, 1'b0);
    chk(rdata[15:1] === 15'h0, "R5 upper bits cleared", 32'(rdata), 32'(rdata[0]));
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R6 done stays low when idle", 32'(done), 0);
    summary();
    $finish;
  end
endmodule